// File: doc/BRIEF.md
# Prioritized Interrupt Bank

This block gathers 32 active-low interrupt lines into one bank. Each line carries its own settings: a capture mode (falling edge or low level), a 5-bit priority, and a routing choice between the normal request output and the fast request output. Captured lines are held in a pending vector and filtered by a per-line mask. For each output class, the bank then picks the highest-priority candidate.

Once a winner is chosen for a class, its line number is latched and the request output for that class stays asserted. Software reads the latched number through the register port. It services the source, then writes an acknowledge bit. A falling-edge winner has its pending bit cleared by that acknowledge. One cycle later, arbitration picks the next winner.

A single global gate can silence both outputs. A build parameter marks the instance as the primary bank; any other bank can never route a line to the fast output.

Top module: `prio_intc`

## Requirements
- R1: After reset, the mask register (word 1) reads all ones, pending (word 0) reads zero, the global gate (word 5, bit 0) reads 1, and both request outputs are low.
- R2: Line n has a settings word at word address 32+n. Bit 0 selects fast routing, bit 1 selects level capture (1) or falling-edge capture (0), and bits 6:2 hold the priority. The word reads back as written.
- R3: When the instance is not the primary bank, bit 0 of every settings word stays 0 and the fast request output never asserts.
- R4: A line in falling-edge mode sets its pending bit on a high-to-low transition. The bit stays set after the line returns high.
- R5: A line in level mode shows pending exactly while its input is low, one cycle after the input changes.
- R6: Writing word 0 clears every edge-captured pending bit whose written data bit is 0. Writing zero clears all of them.
- R7: A line whose mask bit is 1 is still recorded in the pending register, but it is never chosen as a winner.
- R8: While the global gate bit is 1, both request outputs are low. Writing 0 to the gate lets latched requests through.
- R9: The candidate with the numerically lowest priority wins. Among equal priorities, the lowest line number wins.
- R10: A latched winner number and its request stay unchanged until the acknowledge for that class, even if a better candidate appears.
- R11: Writing word 4 acknowledges: bit 0 acknowledges the normal class and bit 1 the fast class. The request drops in the cycle after the write. An edge-mode winner loses its pending bit, and a new winner may be latched one cycle later.
- R12: The winner number of a class, at words 2 (normal) and 3 (fast) and on the number outputs, reads 0 while that class holds no request.
- R13: Lines routed to the fast class compete only for the fast output. Normal lines compete only for the normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 7 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| line_n | input | 32 | Active-low interrupt inputs |
| irq_o | output | 1 | Normal-class request |
| fiq_o | output | 1 | Fast-class request |
| irq_num_o | output | 5 | Latched normal-class winner |
| fiq_num_o | output | 5 | Latched fast-class winner |

## Verification
The assertions rely on a few assumptions about the inputs. The line inputs are synchronous to the clock. Only one register write occurs per cycle. The acknowledge strobe for a class is the only event that can release a held winner.

The stimulus respects these assumptions. It changes lines and register writes only on the falling clock edge. It releases level lines before acknowledging, so that re-arbitration results are unambiguous. It drives edge-mode lines with single-cycle low pulses, so each pulse produces exactly one capture.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int PRIO_W = 5;
  localparam int CFG_W  = PRIO_W + 2;

  // word addresses of the register port
  localparam int A_PEND  = 0;
  localparam int A_MASK  = 1;
  localparam int A_INUM  = 2;
  localparam int A_FNUM  = 3;
  localparam int A_CTRL  = 4;
  localparam int A_GATE  = 5;
  localparam int A_CFG0  = 32;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              lvl;
    logic              fast;
  } line_cfg_t;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int N_LINES    = 32,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32,
  parameter bit PRIMARY    = 1'b1,
  localparam int LW        = $clog2(N_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [N_LINES-1:0]        pend_q,
  input  logic [LW-1:0]             inum,
  input  logic [LW-1:0]             fnum,
  output line_cfg_t [N_LINES-1:0]   cfg_q,
  output logic [N_LINES-1:0]        mask_q,
  output logic                      gate_q,
  output logic                      pend_wr,
  output logic                      ack_irq,
  output logic                      ack_fiq,
  output logic [DATA_W-1:0]         rdata
);
  localparam logic [ADDR_W-1:0] AD_PEND = ADDR_W'(A_PEND);
  localparam logic [ADDR_W-1:0] AD_MASK = ADDR_W'(A_MASK);
  localparam logic [ADDR_W-1:0] AD_INUM = ADDR_W'(A_INUM);
  localparam logic [ADDR_W-1:0] AD_FNUM = ADDR_W'(A_FNUM);
  localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_GATE = ADDR_W'(A_GATE);
  localparam logic [ADDR_W-1:0] AD_CFG0 = ADDR_W'(A_CFG0);

  logic [N_LINES-1:0] mask_d;
  logic               mask_en;
  logic               gate_d;
  logic               gate_en;

  assign pend_wr = wr_en && (addr == AD_PEND);
  assign ack_irq = wr_en && (addr == AD_CTRL) && wdata[0];
  assign ack_fiq = wr_en && (addr == AD_CTRL) && wdata[1];

  // per-line settings words
  for (genvar g = 0; g < N_LINES; g++) begin : g_cfg
    logic      cfg_en;
    line_cfg_t cfg_d;
    assign cfg_en = wr_en && (addr == ADDR_W'(A_CFG0 + g));
    always_comb begin
      cfg_d = wdata[CFG_W-1:0];
      if (!PRIMARY) cfg_d.fast = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[g] <= '0;
      else if (cfg_en) cfg_q[g] <= cfg_d;
    end
  end

  assign mask_en = wr_en && (addr == AD_MASK);
  assign mask_d  = wdata[N_LINES-1:0];
  assign gate_en = wr_en && (addr == AD_GATE);
  assign gate_d  = wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      gate_q <= 1'b1;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (gate_en) gate_q <= gate_d;
    end
  end

  // read mux
  logic [ADDR_W-1:0] cfg_off;
  assign cfg_off = addr - AD_CFG0;

  always_comb begin
    rdata = '0;
    if (addr >= AD_CFG0 && cfg_off < ADDR_W'(N_LINES)) begin
      rdata = DATA_W'(cfg_q[cfg_off[LW-1:0]]);
    end else begin
      case (addr)
        AD_PEND: rdata = DATA_W'(pend_q);
        AD_MASK: rdata = DATA_W'(mask_q);
        AD_INUM: rdata = DATA_W'(inum);
        AD_FNUM: rdata = DATA_W'(fnum);
        AD_GATE: rdata = DATA_W'(gate_q);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_intc_capture.sv
module prio_intc_capture #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_n,
  input  logic [N_LINES-1:0] lvl,
  input  logic               pend_wr,
  input  logic [N_LINES-1:0] keep,
  input  logic [N_LINES-1:0] ack_clr,
  output logic [N_LINES-1:0] pend_q
);
  logic [N_LINES-1:0] line_q;
  logic [N_LINES-1:0] fall;
  logic [N_LINES-1:0] hold;
  logic [N_LINES-1:0] edge_d;
  logic [N_LINES-1:0] pend_d;

  always_comb begin
    fall   = line_q & ~line_n;
    hold   = pend_q & ~ack_clr & (pend_wr ? keep : {N_LINES{1'b1}});
    edge_d = hold | fall;
    pend_d = (lvl & ~line_n) | (~lvl & edge_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '1;
      pend_q <= '0;
    end else begin
      line_q <= line_n;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int N_LINES = 32,
  localparam int LW     = $clog2(N_LINES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_LINES-1:0]             cand,
  input  logic [N_LINES-1:0][PRIO_W-1:0] prio,
  input  logic                           open,
  input  logic                           ack,
  output logic                           held_q,
  output logic [LW-1:0]                  num_q,
  output logic [N_LINES-1:0]             ack_clr
);
  logic              found;
  logic [LW-1:0]     best;
  logic [PRIO_W-1:0] best_p;
  logic              held_d;
  logic [LW-1:0]     num_d;

  // linear scan: strict compare keeps the lowest index on ties
  always_comb begin
    found  = 1'b0;
    best   = '0;
    best_p = '1;
    for (int i = 0; i < N_LINES; i++) begin
      if (cand[i] && (!found || prio[i] < best_p)) begin
        found  = 1'b1;
        best   = LW'(i);
        best_p = prio[i];
      end
    end
  end

  always_comb begin
    held_d = held_q;
    num_d  = num_q;
    if (ack) begin
      held_d = 1'b0;
      num_d  = '0;
    end else if (!held_q && found && open) begin
      held_d = 1'b1;
      num_d  = best;
    end
  end

  always_comb begin
    ack_clr = '0;
    if (ack && held_q) ack_clr[num_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      num_q  <= '0;
    end else begin
      held_q <= held_d;
      num_q  <= num_d;
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter bit PRIMARY = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic [N_LINES-1:0]         line_n,
  output logic                       irq_o,
  output logic                       fiq_o,
  output logic [$clog2(N_LINES)-1:0] irq_num_o,
  output logic [$clog2(N_LINES)-1:0] fiq_num_o
);
  localparam int LW = $clog2(N_LINES);

  logic [1:0] rst_sync;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  line_cfg_t [N_LINES-1:0]         cfg_q;
  logic [N_LINES-1:0]              mask_q;
  logic                            gate_q;
  logic                            pend_wr;
  logic                            ack_irq;
  logic                            ack_fiq;
  logic [N_LINES-1:0]              pend_q;
  logic [N_LINES-1:0]              lvl;
  logic [N_LINES-1:0]              fast;
  logic [N_LINES-1:0][PRIO_W-1:0]  prio;
  logic [N_LINES-1:0]              cand_irq;
  logic [N_LINES-1:0]              cand_fiq;
  logic [N_LINES-1:0]              clr_irq;
  logic [N_LINES-1:0]              clr_fiq;
  logic                            irq_held;
  logic                            fiq_held;
  logic [LW-1:0]                   inum;
  logic [LW-1:0]                   fnum;

  prio_intc_regs #(
    .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIMARY(PRIMARY)
  ) u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pend_q(pend_q), .inum(inum), .fnum(fnum), .cfg_q(cfg_q),
    .mask_q(mask_q), .gate_q(gate_q), .pend_wr(pend_wr),
    .ack_irq(ack_irq), .ack_fiq(ack_fiq), .rdata(rdata)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_split
    assign lvl[g]  = cfg_q[g].lvl;
    assign fast[g] = cfg_q[g].fast;
    assign prio[g] = cfg_q[g].prio;
  end

  prio_intc_capture #(.N_LINES(N_LINES)) u_cap (
    .clk(clk), .rst_n(srst_n), .line_n(line_n), .lvl(lvl),
    .pend_wr(pend_wr), .keep(wdata[N_LINES-1:0]),
    .ack_clr(clr_irq | clr_fiq), .pend_q(pend_q)
  );

  assign cand_irq = pend_q & ~mask_q & ~fast;

  if (PRIMARY) begin : g_fast
    assign cand_fiq = pend_q & ~mask_q & fast;
  end else begin : g_nofast
    assign cand_fiq = '0;
  end

  prio_intc_arb #(.N_LINES(N_LINES)) u_arb_irq (
    .clk(clk), .rst_n(srst_n), .cand(cand_irq), .prio(prio),
    .open(~gate_q), .ack(ack_irq), .held_q(irq_held), .num_q(inum),
    .ack_clr(clr_irq)
  );

  prio_intc_arb #(.N_LINES(N_LINES)) u_arb_fiq (
    .clk(clk), .rst_n(srst_n), .cand(cand_fiq), .prio(prio),
    .open(~gate_q), .ack(ack_fiq), .held_q(fiq_held), .num_q(fnum),
    .ack_clr(clr_fiq)
  );

  assign irq_o     = irq_held & ~gate_q;
  assign fiq_o     = fiq_held & ~gate_q;
  assign irq_num_o = inum;
  assign fiq_num_o = fnum;
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N_LINES = 32,
  parameter bit PRIMARY = 1'b1,
  localparam int LW     = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               srst_n,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [LW-1:0]      irq_num_o,
  input logic               irq_held,
  input logic               gate_q,
  input logic               ack_irq,
  input logic [N_LINES-1:0] cand_irq
);
  logic [N_LINES-1:0] live_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) live_q <= '0;
    else         live_q <= cand_irq;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (!irq_o && !fiq_o)); // R1

  AST_FAST_PRIMARY_ONLY: assert property (@(posedge clk) disable iff (!srst_n)
    !PRIMARY |-> !fiq_o); // R3

  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq_held) |-> live_q[irq_num_o]); // R7

  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!srst_n)
    gate_q |-> (!irq_o && !fiq_o)); // R8

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_held && !ack_irq) |=> (irq_held && $stable(irq_num_o))); // R10

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_held && ack_irq) |=> !irq_o); // R11

  AST_IDLE_NUM_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    !irq_held |-> (irq_num_o == '0)); // R12
endmodule

bind prio_intc prio_intc_chk #(.N_LINES(N_LINES), .PRIMARY(PRIMARY)) u_chk (
  .clk(clk), .srst_n(srst_n), .irq_o(irq_o), .fiq_o(fiq_o),
  .irq_num_o(irq_num_o), .irq_held(irq_held), .gate_q(gate_q),
  .ack_irq(ack_irq), .cand_irq(cand_irq)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic        clk;
  logic        rst_n;
  logic        wr0, wr1;
  logic [6:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata0, rdata1;
  logic [31:0] in0, in1;
  logic        irq0, fiq0, irq1, fiq1;
  logic [4:0]  inum0, fnum0, inum1, fnum1;

  int total = 0;
  int bad   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  prio_intc #(.PRIMARY(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr0), .addr(addr), .wdata(wdata),
    .rdata(rdata0), .line_n(in0), .irq_o(irq0), .fiq_o(fiq0),
    .irq_num_o(inum0), .fiq_num_o(fnum0)
  );

  prio_intc #(.PRIMARY(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr1), .addr(addr), .wdata(wdata),
    .rdata(rdata1), .line_n(in1), .irq_o(irq1), .fiq_o(fiq1),
    .irq_num_o(inum1), .fiq_num_o(fnum1)
  );

  // {active lines, expected winner, expected request}
  localparam logic [37:0] VEC [6] = '{
    {32'h0000_0408, 5'd10, 1'b1},
    {32'h0000_0021, 5'd0,  1'b1},
    {32'h8000_0200, 5'd31, 1'b1},
    {32'h0080_4000, 5'd23, 1'b1},
    {32'h0000_0000, 5'd0,  1'b0},
    {32'h0804_0020, 5'd5,  1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int a, input logic [31:0] d);
    @(negedge clk);
    addr  = 7'(a);
    wdata = d;
    if (bank == 0) wr0 = 1'b1; else wr1 = 1'b1;
    @(negedge clk);
    wr0 = 1'b0;
    wr1 = 1'b0;
  endtask

  task automatic rd(input int bank, input int a, output logic [31:0] d);
    addr = 7'(a);
    #1;
    d = (bank == 0) ? rdata0 : rdata1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    wr0 = 1'b0; wr1 = 1'b0;
    addr = '0; wdata = '0;
    in0 = '1; in1 = '1;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 / R12 reset state
    rd(0, 1, r); chk(r, 32'hFFFF_FFFF, "R1 mask");
    rd(0, 0, r); chk(r, 32'h0, "R1 pending");
    rd(0, 5, r); chk(r, 32'h1, "R1 gate");
    chk({30'd0, irq0, fiq0}, 32'h0, "R1 requests");
    rd(0, 2, r); chk(r, 32'h0, "R12 idle number");

    // all lines level, priority (7*n)%32
    for (int n = 0; n < 32; n++) wr(0, 32 + n, (((7 * n) % 32) << 2) | 2);
    rd(0, 32 + 5, r); chk(r, 32'd14, "R2 settings readback");
    wr(0, 1, 32'h0);

    // R8 gate closed blocks; open lets through
    in0 = ~(32'h1 << 10);
    idle(3);
    chk({31'd0, irq0}, 32'h0, "R8 gate closed");
    rd(0, 0, r); chk(r, 32'h400, "R5 level pending");
    wr(0, 5, 32'h0);
    idle(2);
    chk({31'd0, irq0}, 32'h1, "R8 gate open");
    chk({27'd0, inum0}, 32'd10, "R8 winner");
    in0 = '1; idle(2);
    rd(0, 0, r); chk(r, 32'h0, "R5 level released");
    wr(0, 4, 32'h1); idle(2);

    // R9 table of level patterns
    foreach (VEC[k]) begin
      in0 = ~VEC[k][37:6];
      idle(3);
      chk({31'd0, irq0}, {31'd0, VEC[k][0]}, "R9 table request");
      chk({27'd0, inum0}, {27'd0, VEC[k][5:1]}, "R9 table winner");
      in0 = '1; idle(2);
      wr(0, 4, 32'h1); idle(2);
      chk({31'd0, irq0}, 32'h0, "R11 table ack");
    end

    // R10 hold then R11 re-arbitration
    in0 = ~(32'h1 << 20); idle(3);
    chk({27'd0, inum0}, 32'd20, "R10 first winner");
    in0 = ~((32'h1 << 20) | 32'h1); idle(3);
    chk({27'd0, inum0}, 32'd20, "R10 held despite better");
    wr(0, 4, 32'h1); idle(1);
    chk({31'd0, irq0}, 32'h1, "R11 rearbitrated request");
    chk({27'd0, inum0}, 32'd0, "R11 rearbitrated winner");
    in0 = '1; idle(2);
    wr(0, 4, 32'h1); idle(2);

    // R9 tie on equal priority
    wr(0, 32 + 4, (9 << 2) | 2);
    wr(0, 32 + 6, (9 << 2) | 2);
    in0 = ~((32'h1 << 4) | (32'h1 << 6)); idle(3);
    chk({27'd0, inum0}, 32'd4, "R9 tie lowest line");
    in0 = '1; idle(2);
    wr(0, 4, 32'h1); idle(2);

    // R7 masking
    wr(0, 1, 32'h1 << 23);
    in0 = ~(32'h1 << 23); idle(3);
    chk({31'd0, irq0}, 32'h0, "R7 masked no request");
    rd(0, 0, r); chk(r, 32'h1 << 23, "R7 masked still pending");
    wr(0, 1, 32'h0); idle(2);
    chk({27'd0, inum0}, 32'd23, "R7 unmasked winner");
    in0 = '1; idle(2);
    wr(0, 4, 32'h1); idle(2);

    // R4 edge capture, R11 ack clears edge pending
    wr(0, 32 + 12, 4 << 2);
    in0 = ~(32'h1 << 12); idle(1);
    in0 = '1; idle(3);
    rd(0, 0, r); chk(r, 32'h1 << 12, "R4 edge pending held");
    chk({27'd0, inum0}, 32'd12, "R4 edge winner");
    wr(0, 4, 32'h1);
    rd(0, 0, r); chk(r, 32'h0, "R11 edge pending cleared");
    chk({31'd0, irq0}, 32'h0, "R11 edge request dropped");

    // R6 pending write clears edge bits
    wr(0, 1, 32'h1 << 12);
    in0 = ~(32'h1 << 12); idle(1);
    in0 = '1; idle(2);
    rd(0, 0, r); chk(r, 32'h1 << 12, "R6 captured before clear");
    wr(0, 0, 32'h0);
    rd(0, 0, r); chk(r, 32'h0, "R6 cleared by zero write");
    wr(0, 1, 32'h0); idle(2);
    chk({31'd0, irq0}, 32'h0, "R6 nothing left to win");

    // R13 fast routing, R11 per-class acknowledge, R8 gate on held
    wr(0, 32 + 7, 32'h3);
    in0 = ~(32'h1 << 7); idle(3);
    chk({30'd0, fiq0, irq0}, 32'h2, "R13 fast only");
    chk({27'd0, fnum0}, 32'd7, "R13 fast winner");
    rd(0, 3, r); chk(r, 32'd7, "R13 fast number word");
    wr(0, 5, 32'h1);
    chk({31'd0, fiq0}, 32'h0, "R8 gate hides held");
    wr(0, 5, 32'h0);
    chk({31'd0, fiq0}, 32'h1, "R8 gate reopened");
    wr(0, 4, 32'h1); idle(1);
    chk({31'd0, fiq0}, 32'h1, "R11 normal ack leaves fast");
    in0 = '1; idle(2);
    wr(0, 4, 32'h2);
    chk({31'd0, fiq0}, 32'h0, "R11 fast ack");
    rd(0, 3, r); chk(r, 32'h0, "R12 fast idle number");

    // R3 secondary bank
    wr(1, 32 + 2, 32'h7F);
    rd(1, 32 + 2, r); chk(r, 32'h7E, "R3 fast bit forced");
    wr(1, 5, 32'h0);
    wr(1, 1, 32'h0);
    in1 = ~(32'h1 << 2); idle(3);
    chk({30'd0, fiq1, irq1}, 32'h1, "R3 routed normal");
    chk({27'd0, inum1}, 32'd2, "R3 winner");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule